// File: doc/BRIEF.md
# Double-Word Stack-to-Locals Store Sequencer

This block is the control and datapath slice of a stack-machine core that carries out one instruction: it moves the two topmost stack words into two adjacent local-variable slots. The top-of-stack word goes to slot `i+1` and the word beneath it goes to slot `i`. The slot index `i` is an unsigned byte, taken from the instruction stream and latched when the operation starts. The block holds the stack pointer, the local-frame base, a cached top-of-stack word and the memory address and data registers. It drives a word-addressed memory port through single-cycle read and write strobes.

The work is a fixed eight-step micro-sequence. It writes the cached top word, reads the word below it, writes that word to the lower slot, and then reads the new top so that the cache can be refilled. Each read is followed by a wait step, because read data reaches the data register one cycle after the strobe. While the block is idle, a preset strobe loads the stack pointer, frame base and cached top word. A one-cycle `done` pulse shows where a core would dispatch its next opcode. At that point the stack pointer has dropped by two.

Top module: `dwstore_seq`

## Requirements
- R1: After reset the block is idle: `mem_wr`, `mem_rd` and `done` are low, and `sp_o`, `lv_o` and `tos_o` read zero.
- R2: If `start` is sampled high in cycle c while idle, `mem_wr` is high in cycle c+3 only. In that cycle `mem_addr` = LV + i + 1 and `mem_wdata` = the cached top-of-stack word.
- R3: In cycle c+4 only, `mem_rd` is high and `mem_addr` = SP0 − 1. Here SP0 is the stack pointer at start, and `mem_addr` equals the current `sp_o` in that cycle.
- R4: In cycle c+6, `mem_wr` is high with `mem_addr` = LV + i and `mem_wdata` = the word read in R3. That word reflects the R2 write if the addresses coincide.
- R5: In cycle c+7 only, `mem_rd` is high with `mem_addr` = SP0 − 2. No other strobes occur in the sequence.
- R6: `done` is high in cycle c+9 for exactly one cycle. In that cycle `sp_o` = SP0 − 2 and `tos_o` = the word read in R5.
- R7: The index `idx_in` is unsigned and zero-extended. With i = 255, the slot addresses are LV + 255 and LV + 256.
- R8: A `start` pulse while a sequence runs is ignored. It changes neither the running sequence nor the latched index, and it produces no strobe or `done` afterwards.
- R9: `mem_wr` and `mem_rd` are never high in the same cycle, and each stays high for one cycle only.
- R10: `ld` is honoured only while idle. Asserted mid-sequence, it leaves LV, SP and the cached top word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the double-word store (accepted when idle) |
| idx_in | input | IW (8) | Unsigned local slot index, latched on start |
| ld | input | 1 | Preset strobe for SP, LV and the cached top word (idle only) |
| sp_in | input | AW (16) | Preset stack pointer |
| lv_in | input | AW (16) | Preset local-frame base |
| tos_in | input | DW (32) | Preset cached top-of-stack word |
| mem_rdata | input | DW (32) | Memory read data, valid in the cycle `mem_rd` is high |
| mem_addr | output | AW (16) | Memory word address (address register) |
| mem_wdata | output | DW (32) | Memory write data (data register) |
| mem_wr | output | 1 | Single-cycle write strobe |
| mem_rd | output | 1 | Single-cycle read strobe |
| done | output | 1 | One-cycle pulse: sequence complete |
| sp_o | output | AW (16) | Current stack pointer |
| lv_o | output | AW (16) | Current local-frame base |
| tos_o | output | DW (32) | Current cached top-of-stack word |

## Verification
If `start` is sampled at the edge that ends cycle c, the four memory strobes fall in cycles c+3, c+4, c+6 and c+7, and `done` with the final SP and cached word falls in cycle c+9. The driver records c and pushes each expected strobe into a queue, tagged with its due cycle, address and data. The data values come from a shadow memory that is updated in strobe order. A monitor samples on the falling edge, pops one item per strobe, and compares the cycle number as well as the address and data. A strobe that comes early, late or unannounced is therefore reported. The final values are read in cycle c+9, and `done` is read low again in c+10.

// File: rtl/dws_pkg.sv
`timescale 1ns/1ps
package dws_pkg;

    // Micro-sequence position; the order of these steps is the behaviour.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SLOT_HI,    // address register <- frame + index + 1
        ST_WR_HI,      // data register <- cached top, issue write
        ST_RD_NOS,     // SP--, address <- SP, issue read
        ST_WAIT_NOS,   // read data lands in data register
        ST_WR_LO,      // address <- frame + index, issue write
        ST_RD_TOS,     // SP--, address <- SP, issue read
        ST_WAIT_TOS,   // read data lands in data register
        ST_LOAD_TOS    // cached top <- data register, finish
    } step_e;

    typedef enum logic [1:0] {
        MAR_KEEP,
        MAR_SLOT_HI,
        MAR_SLOT_LO,
        MAR_SP_DEC
    } mar_src_e;

    // Control word emitted for each step.
    typedef struct packed {
        mar_src_e mar_src;
        logic     sp_dec;
        logic     mdr_from_tos;
        logic     issue_wr;
        logic     issue_rd;
        logic     tos_from_mdr;
        logic     finish;
    } uop_t;

    function automatic step_e advance(input step_e s, input logic go);
        step_e n;
        case (s)
            ST_IDLE:     n = go ? ST_SLOT_HI : ST_IDLE;
            ST_SLOT_HI:  n = ST_WR_HI;
            ST_WR_HI:    n = ST_RD_NOS;
            ST_RD_NOS:   n = ST_WAIT_NOS;
            ST_WAIT_NOS: n = ST_WR_LO;
            ST_WR_LO:    n = ST_RD_TOS;
            ST_RD_TOS:   n = ST_WAIT_TOS;
            ST_WAIT_TOS: n = ST_LOAD_TOS;
            default:     n = ST_IDLE;
        endcase
        return n;
    endfunction

    function automatic uop_t decode_step(input step_e s);
        uop_t u;
        u              = '0;
        u.mar_src      = MAR_KEEP;
        case (s)
            ST_SLOT_HI:  u.mar_src = MAR_SLOT_HI;
            ST_WR_HI: begin
                u.mdr_from_tos = 1'b1;
                u.issue_wr     = 1'b1;
            end
            ST_RD_NOS, ST_RD_TOS: begin
                u.sp_dec   = 1'b1;
                u.mar_src  = MAR_SP_DEC;
                u.issue_rd = 1'b1;
            end
            ST_WR_LO: begin
                u.mar_src  = MAR_SLOT_LO;
                u.issue_wr = 1'b1;
            end
            ST_LOAD_TOS: begin
                u.tos_from_mdr = 1'b1;
                u.finish       = 1'b1;
            end
            default: ;
        endcase
        return u;
    endfunction

endpackage

// File: rtl/dws_sequencer.sv
`timescale 1ns/1ps
module dws_sequencer
    import dws_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    output step_e step,
    output uop_t  uop,
    output logic  busy
);

    step_e step_q;

    always_ff @(posedge clk) begin
        if (rst) step_q <= ST_IDLE;
        else     step_q <= advance(step_q, start);
    end

    assign step = step_q;
    assign busy = (step_q != ST_IDLE);
    assign uop  = decode_step(step_q);

endmodule

// File: rtl/dws_addr_unit.sv
`timescale 1ns/1ps
module dws_addr_unit #(
    parameter int AW = 16,
    parameter int IW = 8
) (
    input  logic [AW-1:0] lv,
    input  logic [AW-1:0] sp,
    input  logic [IW-1:0] idx,
    output logic [AW-1:0] slot_lo,
    output logic [AW-1:0] slot_hi,
    output logic [AW-1:0] sp_less
);

    logic [AW-1:0] idx_ext;

    generate
        if (IW < AW) begin : g_pad
            assign idx_ext = {{(AW-IW){1'b0}}, idx};
        end else begin : g_cut
            assign idx_ext = idx[AW-1:0];
        end
    endgenerate

    assign slot_lo = lv + idx_ext;
    assign slot_hi = slot_lo + AW'(1);
    assign sp_less = sp - AW'(1);

endmodule

// File: rtl/dws_datapath.sv
`timescale 1ns/1ps
module dws_datapath
    import dws_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  uop_t          uop,
    input  logic          busy,
    input  logic          ld,
    input  logic [AW-1:0] sp_in,
    input  logic [AW-1:0] lv_in,
    input  logic [DW-1:0] tos_in,
    input  logic [AW-1:0] slot_lo,
    input  logic [AW-1:0] slot_hi,
    input  logic [AW-1:0] sp_less,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] sp_q,
    output logic [AW-1:0] lv_q,
    output logic [DW-1:0] tos_q,
    output logic [AW-1:0] mar_q,
    output logic [DW-1:0] mdr_q,
    output logic          wr_q,
    output logic          rd_q,
    output logic          done_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q   <= '0;
            lv_q   <= '0;
            tos_q  <= '0;
            mar_q  <= '0;
            mdr_q  <= '0;
            wr_q   <= 1'b0;
            rd_q   <= 1'b0;
            done_q <= 1'b0;
        end else begin
            wr_q   <= uop.issue_wr;
            rd_q   <= uop.issue_rd;
            done_q <= uop.finish;

            if (ld && !busy) begin
                sp_q  <= sp_in;
                lv_q  <= lv_in;
                tos_q <= tos_in;
            end else begin
                if (uop.sp_dec)       sp_q  <= sp_less;
                if (uop.tos_from_mdr) tos_q <= mdr_q;
            end

            case (uop.mar_src)
                MAR_SLOT_HI: mar_q <= slot_hi;
                MAR_SLOT_LO: mar_q <= slot_lo;
                MAR_SP_DEC:  mar_q <= sp_less;
                default:     mar_q <= mar_q;
            endcase

            // Read data is captured at the edge that closes the strobe cycle.
            if (rd_q)                  mdr_q <= mem_rdata;
            else if (uop.mdr_from_tos) mdr_q <= tos_q;
        end
    end

endmodule

// File: rtl/dwstore_seq.sv
`timescale 1ns/1ps
module dwstore_seq
    import dws_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int IW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [IW-1:0] idx_in,
    input  logic          ld,
    input  logic [AW-1:0] sp_in,
    input  logic [AW-1:0] lv_in,
    input  logic [DW-1:0] tos_in,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_wr,
    output logic          mem_rd,
    output logic          done,
    output logic [AW-1:0] sp_o,
    output logic [AW-1:0] lv_o,
    output logic [DW-1:0] tos_o
);

    step_e         step;
    uop_t          uop;
    logic          busy;
    logic [IW-1:0] ibr_q;
    logic [AW-1:0] slot_lo, slot_hi, sp_less;
    logic [AW-1:0] sp_q, lv_q, mar_q;
    logic [DW-1:0] tos_q, mdr_q;
    logic          wr_q, rd_q, done_q;

    // Instruction byte register: the index is frozen for the whole sequence.
    always_ff @(posedge clk) begin
        if (rst)                ibr_q <= '0;
        else if (start && !busy) ibr_q <= idx_in;
    end

    dws_sequencer u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .step  (step),
        .uop   (uop),
        .busy  (busy)
    );

    dws_addr_unit #(.AW(AW), .IW(IW)) u_addr (
        .lv      (lv_q),
        .sp      (sp_q),
        .idx     (ibr_q),
        .slot_lo (slot_lo),
        .slot_hi (slot_hi),
        .sp_less (sp_less)
    );

    dws_datapath #(.AW(AW), .DW(DW)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .uop       (uop),
        .busy      (busy),
        .ld        (ld),
        .sp_in     (sp_in),
        .lv_in     (lv_in),
        .tos_in    (tos_in),
        .slot_lo   (slot_lo),
        .slot_hi   (slot_hi),
        .sp_less   (sp_less),
        .mem_rdata (mem_rdata),
        .sp_q      (sp_q),
        .lv_q      (lv_q),
        .tos_q     (tos_q),
        .mar_q     (mar_q),
        .mdr_q     (mdr_q),
        .wr_q      (wr_q),
        .rd_q      (rd_q),
        .done_q    (done_q)
    );

    assign mem_addr  = mar_q;
    assign mem_wdata = mdr_q;
    assign mem_wr    = wr_q;
    assign mem_rd    = rd_q;
    assign done      = done_q;
    assign sp_o      = sp_q;
    assign lv_o      = lv_q;
    assign tos_o     = tos_q;

endmodule

// File: rtl/dws_checker.sv
`timescale 1ns/1ps
module dws_checker #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          mem_wr,
    input logic          mem_rd,
    input logic [AW-1:0] mem_addr,
    input logic          done,
    input logic [AW-1:0] sp_o
);

    logic          busy_q;
    logic [AW-1:0] sp_start;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            sp_start <= '0;
        end else begin
            busy_q <= busy;
            if (busy && !busy_q) sp_start <= sp_o;
        end
    end

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $fell(rst) |-> (!mem_wr && !mem_rd && !done));

    a_r9_strobe_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(mem_wr && mem_rd));

    a_r9_wr_single: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> !mem_wr);

    a_r9_rd_single: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> !mem_rd);

    a_r3_read_at_sp: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> (mem_addr == sp_o));

    a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r6_done_when_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r6_sp_dropped_two: assert property (@(posedge clk) disable iff (rst)
        done |-> (sp_o == sp_start - AW'(2)));

endmodule

bind dwstore_seq dws_checker #(.AW(AW)) u_dws_checker (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .mem_wr   (mem_wr),
    .mem_rd   (mem_rd),
    .mem_addr (mem_addr),
    .done     (done),
    .sp_o     (sp_o)
);

// File: tb/dwstore_seq_bench.sv
`timescale 1ns/1ps
module dwstore_seq_bench;

    localparam int AW = 16;
    localparam int DW = 32;
    localparam int IW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [IW-1:0] idx_in = '0;
    logic          ld = 1'b0;
    logic [AW-1:0] sp_in = '0;
    logic [AW-1:0] lv_in = '0;
    logic [DW-1:0] tos_in = '0;
    logic [DW-1:0] mem_rdata;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_wr, mem_rd, done;
    logic [AW-1:0] sp_o, lv_o;
    logic [DW-1:0] tos_o;

    always #2.5 clk = ~clk;

    dwstore_seq #(.AW(AW), .DW(DW), .IW(IW)) u_dwstore_seq (
        .clk(clk), .rst(rst), .start(start), .idx_in(idx_in), .ld(ld),
        .sp_in(sp_in), .lv_in(lv_in), .tos_in(tos_in), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wr(mem_wr),
        .mem_rd(mem_rd), .done(done), .sp_o(sp_o), .lv_o(lv_o), .tos_o(tos_o)
    );

    // Memory model: asynchronous read, write at the clock edge.
    logic [DW-1:0] mem  [0:1023];
    logic [DW-1:0] refm [0:1023];
    assign mem_rdata = mem[mem_addr[9:0]];
    always @(posedge clk) if (mem_wr) mem[mem_addr[9:0]] <= mem_wdata;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    typedef struct {
        bit          is_wr;
        int          due;
        int          addr;
        logic [31:0] data;
        string       req;
    } op_t;
    op_t sbq[$];
    string stray_req = "R9";

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: pops one expected item per observed strobe.
    always @(negedge clk) begin
        op_t e;
        if (!rst && (mem_wr || mem_rd)) begin
            check(!(mem_wr && mem_rd), "R9", "both strobes", {mem_wr, mem_rd}, 2'b00);
            if (sbq.size() == 0) begin
                check(1'b0, stray_req, "unexpected strobe at addr", mem_addr, 0);
            end else begin
                e = sbq.pop_front();
                check(mem_wr == e.is_wr, e.req, "strobe kind (1=write)", mem_wr, e.is_wr);
                check(cyc == e.due, e.req, "strobe cycle", cyc, e.due);
                check(mem_addr == AW'(e.addr), e.req, "strobe address", mem_addr, e.addr);
                if (e.is_wr)
                    check(mem_wdata == e.data, e.req, "write data", mem_wdata, e.data);
            end
        end
    end

    task automatic wait_cyc(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic run_op(input int sp0, input int lv, input logic [31:0] tos0,
                          input int idx, input bit poke_start, input bit poke_ld,
                          input string tag);
        int c;
        int a_hi, a_lo;
        logic [31:0] v1, v2;
        string fin;
        fin  = poke_ld ? "R10" : "R6";
        a_lo = lv + idx;
        a_hi = lv + idx + 1;
        @(negedge clk);
        ld = 1'b1; sp_in = AW'(sp0); lv_in = AW'(lv); tos_in = tos0;
        @(negedge clk);
        ld = 1'b0; start = 1'b1; idx_in = IW'(idx);
        c = cyc;
        // Predict in strobe order against the shadow memory.
        refm[a_hi] = tos0;
        sbq.push_back('{1'b1, c + 3, a_hi, tos0, (tag == "R7") ? "R7" : "R2"});
        sbq.push_back('{1'b0, c + 4, sp0 - 1, 32'h0, "R3"});
        v1 = refm[sp0 - 1];
        refm[a_lo] = v1;
        sbq.push_back('{1'b1, c + 6, a_lo, v1, poke_start ? "R8" : ((tag == "R7") ? "R7" : "R4")});
        sbq.push_back('{1'b0, c + 7, sp0 - 2, 32'h0, "R5"});
        v2 = refm[sp0 - 2];
        @(negedge clk);
        start = 1'b0;
        idx_in = '0;
        if (poke_ld) begin
            wait_cyc(c + 2);
            ld = 1'b1; sp_in = '0; lv_in = '0; tos_in = 32'h0BAD_0BAD;
            @(negedge clk);
            ld = 1'b0;
        end
        if (poke_start) begin
            wait_cyc(c + 4);
            start = 1'b1; idx_in = 8'h40;
            @(negedge clk);
            start = 1'b0;
        end
        wait_cyc(c + 8);
        check(done == 1'b0, "R6", "done early", done, 0);
        wait_cyc(c + 9);
        check(done == 1'b1, "R6", "done at c+9", done, 1);
        check(sp_o == AW'(sp0 - 2), fin, "final SP", sp_o, sp0 - 2);
        check(tos_o == v2, fin, "final cached top", tos_o, v2);
        check(lv_o == AW'(lv), fin, "frame base kept", lv_o, lv);
        check(sbq.size() == 0, "R5", "pending strobes", sbq.size(), 0);
        check(mem[a_hi] == refm[a_hi], "R2", "slot i+1 content", mem[a_hi], refm[a_hi]);
        check(mem[a_lo] == refm[a_lo], "R4", "slot i content", mem[a_lo], refm[a_lo]);
        @(negedge clk);
        check(done == 1'b0, "R6", "done one cycle", done, 0);
        if (poke_start) begin
            stray_req = "R8";
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                check(done == 1'b0, "R8", "done after ignored start", done, 0);
            end
            stray_req = "R9";
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 1024; k++) begin
            mem[k]  = 32'hA500_0000 + 32'(k * 7);
            refm[k] = 32'hA500_0000 + 32'(k * 7);
        end
        repeat (3) @(negedge clk);
        check(mem_wr == 1'b0, "R1", "write strobe in reset", mem_wr, 0);
        rst = 1'b0;
        @(negedge clk);
        check(mem_wr == 1'b0 && mem_rd == 1'b0, "R1", "strobes after reset", {mem_wr, mem_rd}, 0);
        check(done == 1'b0, "R1", "done after reset", done, 0);
        check(sp_o == '0 && lv_o == '0 && tos_o == '0, "R1", "registers after reset",
              {sp_o, lv_o}, 0);

        run_op(200, 20, 32'hDEAD_BEEF, 3, 1'b0, 1'b0, "R2");
        run_op(700, 100, 32'h1234_5678, 255, 1'b0, 1'b0, "R7");
        // Slot i+1 coincides with SP-1: the read must see the first write.
        run_op(47, 40, 32'hCAFE_F00D, 5, 1'b0, 1'b0, "R4");
        run_op(300, 10, 32'h0000_1111, 0, 1'b1, 1'b0, "R8");
        run_op(900, 600, 32'h7777_2222, 17, 1'b0, 1'b1, "R10");
        run_op(898, 600, 32'h5555_AAAA, 1, 1'b0, 1'b0, "R2");

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule